// File: doc/BRIEF.md
# Bulk Erase Algorithm Sequencer

This block runs the whole electrical erase procedure for a parallel flash device that erases all of its bytes at once. A local controller pulses `start`. The sequencer then drives the device bus through four phases. First it writes every byte to zero. Then it issues the two-write erase launch and waits a programmed erase interval. Finally it steps through a verify loop, one byte at a time, in ascending address order. When a byte fails verify, the chip is erased again and checking resumes at that same byte. It does not restart from byte zero.

Electrical timing is expressed in clock cycles. The erase interval comes from `cfg_erase_cycles`, and the cap on erase pulses comes from `cfg_max_pulses`. Both are captured when `start` is accepted. The controller side is plain level and pulse control with no streaming data. `busy`, `done` and `error` are levels, and `start` needs no handshake because it is simply ignored while a run is active. Write cycles drive address and data before the write-enable low pulse and keep them until after it. Reads drop output-enable with the data bus released.

Command codes used on the device bus are 40h (program setup), 20h (erase, written twice), A0h (erase verify) and 00h (read mode). Every command write carries the current byte address. The program data written is 00h.

Top module: `bulk_erase_sequencer`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, `fl_dq_oe` is low, and `busy`, `done` and `error` are low.
- R2: Pre-program phase: for each address from 0 upward, the block writes 40h and then 00h at that address and reads the byte back. If the readback is not 00h, it writes 00h (read mode) at that address and ends with `error`. The erase starts only after every byte reads back 00h.
- R3: The erase is launched by exactly two consecutive 20h writes, with no other bus write between them.
- R4: After the second 20h write, the chip is deselected (`fl_ce_n` high) for exactly `cfg_erase_cycles`+1 clock cycles (`cfg_erase_cycles` ≥ 1). The next bus write is A0h at the address to be verified.
- R5: Verify visits addresses in ascending order. Each read is preceded by an A0h write carrying that read's address. A read of FFh passes the byte.
- R6: A failed verify leads to 20h, 20h, the erase interval, and then A0h at the same failing address. Verification continues from that address.
- R7: After the last address passes, the block writes 00h at the last address. It then raises `done` and drops `busy`.
- R8: When a byte fails and the number of erase pulses already issued equals `cfg_max_pulses` (minimum 1), the block writes 00h at that address and raises `error` instead of erasing again. A byte that passes on exactly the last allowed pulse completes normally.
- R9: During each write cycle, `fl_ce_n` is low and address and data are valid at least one cycle before `fl_we_n` falls. They do not change while `fl_we_n` is low and stay for at least one cycle after it rises.
- R10: `busy` is high from the cycle after `start` is accepted until `done` or `error` rises. Accepting `start` clears `done` and `error`. A `start` pulse while `busy` has no effect on the bus sequence.
- R11: `fl_oe_n` is low only while `fl_we_n` is high and `fl_dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a full erase run (ignored while busy) |
| cfg_erase_cycles | input | ERASE_CNT_W | Erase interval in clocks, captured at start |
| cfg_max_pulses | input | PULSE_W | Erase pulse cap, captured at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with every byte verified |
| error | output | 1 | Run aborted: pre-program failure or pulse cap reached |
| fl_ce_n | output | 1 | Device chip enable, active low |
| fl_we_n | output | 1 | Device write enable, active low |
| fl_oe_n | output | 1 | Device output enable, active low |
| fl_addr | output | ADDR_W | Device byte address |
| fl_dq_out | output | 8 | Data driven toward the device |
| fl_dq_oe | output | 1 | High when `fl_dq_out` should drive the data bus |
| fl_dq_in | input | 8 | Data returned by the device |

## Verification
A device model in the bench keeps a per-byte count of erase pulses needed. A uniform array with every byte needing one pulse shows the plain pass through all phases and the exact erase interval. Scattered weak bytes show that a re-erase resumes at the failing address and not at zero. A weak byte that needs exactly the allowed number of pulses separates an off-by-one in the cap from correct behaviour, and a byte beyond the cap must end in error. A byte whose bits cannot be programmed must stop the run before any erase. A stray `start` in the middle of a run must leave the write sequence unchanged.

// File: rtl/bulk_erase_pkg.sv
package bulk_erase_pkg;

  localparam int DW = 8;

  localparam logic [DW-1:0] CMD_READ    = 8'h00;
  localparam logic [DW-1:0] CMD_PROG    = 8'h40;
  localparam logic [DW-1:0] CMD_ERASE   = 8'h20;
  localparam logic [DW-1:0] CMD_VERIFY  = 8'hA0;
  localparam logic [DW-1:0] PROG_VALUE  = 8'h00;
  localparam logic [DW-1:0] ERASED_BYTE = 8'hFF;

  typedef enum logic {OP_WRITE, OP_READ} bus_op_e;

  typedef enum logic [2:0] {
    E_IDLE, E_SETUP, E_STROBE, E_HOLD, E_READ
  } eng_state_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PP_CMD, S_PP_DATA, S_PP_READ,
    S_ER_ARM, S_ER_FIRE, S_ER_WAIT,
    S_VF_CMD, S_VF_READ, S_EXIT_OK, S_EXIT_ERR
  } seq_state_e;

endpackage

// File: rtl/flash_bus_engine.sv
module flash_bus_engine
  import bulk_erase_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int WE_LOW_CYC = 2,
  parameter int RD_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  bus_op_e           req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_data,
  output logic              ack,
  output logic [DW-1:0]     rdata,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DW-1:0]     fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [DW-1:0]     fl_dq_in
);

  localparam int MAXC = (WE_LOW_CYC > RD_CYC) ? WE_LOW_CYC : RD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  eng_state_e        st_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        E_IDLE: if (req) begin
          addr_q <= req_addr;
          data_q <= req_data;
          if (req_op == OP_WRITE) begin
            st_q <= E_SETUP;
          end else begin
            st_q  <= E_READ;
            cnt_q <= CW'(RD_CYC - 1);
          end
        end
        E_SETUP: begin
          st_q  <= E_STROBE;
          cnt_q <= CW'(WE_LOW_CYC - 1);
        end
        E_STROBE: begin
          if (cnt_q == '0) st_q <= E_HOLD;
          else             cnt_q <= cnt_q - 1'b1;
        end
        E_HOLD: st_q <= E_IDLE;
        E_READ: begin
          if (cnt_q == '0) st_q <= E_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign ack       = (st_q == E_HOLD) || (st_q == E_READ && cnt_q == '0);
  assign rdata     = fl_dq_in;
  assign fl_ce_n   = (st_q == E_IDLE);
  assign fl_we_n   = (st_q != E_STROBE);
  assign fl_oe_n   = (st_q != E_READ);
  assign fl_dq_oe  = (st_q == E_SETUP) || (st_q == E_STROBE) || (st_q == E_HOLD);
  assign fl_addr   = addr_q;
  assign fl_dq_out = data_q;

  // R9: write strobe framed by setup and hold with stable address/data
  a_r9_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> $past(!fl_ce_n) && $past(fl_dq_oe) && $stable(fl_addr) && $stable(fl_dq_out));
  a_r9_stable_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_addr) && $stable(fl_dq_out) && !fl_ce_n);
  a_r9_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> !fl_ce_n && fl_dq_oe && $stable(fl_addr) && $stable(fl_dq_out));
  // R11: no read while writing or while driving the data bus
  a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> fl_we_n && !fl_dq_oe);

endmodule

// File: rtl/erase_interval_timer.sv
module erase_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_val == '0) ? CNT_W'(1) : load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/bulk_erase_sequencer.sv
module bulk_erase_sequencer
  import bulk_erase_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int ERASE_CNT_W = 16,
  parameter int PULSE_W     = 8,
  parameter int WE_LOW_CYC  = 2,
  parameter int RD_CYC      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ERASE_CNT_W-1:0] cfg_erase_cycles,
  input  logic [PULSE_W-1:0]     cfg_max_pulses,
  output logic                   busy,
  output logic                   done,
  output logic                   error,
  output logic                   fl_ce_n,
  output logic                   fl_we_n,
  output logic                   fl_oe_n,
  output logic [ADDR_W-1:0]      fl_addr,
  output logic [DW-1:0]          fl_dq_out,
  output logic                   fl_dq_oe,
  input  logic [DW-1:0]          fl_dq_in
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  seq_state_e             st_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [PULSE_W-1:0]     pulse_q;
  logic [PULSE_W-1:0]     max_q;
  logic [ERASE_CNT_W-1:0] ecyc_q;
  logic                   done_q, err_q;

  logic          bus_req, bus_ack;
  bus_op_e       bus_op;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          tmr_load, tmr_expire;

  always_comb begin
    bus_req   = 1'b1;
    bus_op    = OP_WRITE;
    bus_wdata = CMD_READ;
    case (st_q)
      S_PP_CMD:   bus_wdata = CMD_PROG;
      S_PP_DATA:  bus_wdata = PROG_VALUE;
      S_PP_READ:  bus_op    = OP_READ;
      S_ER_ARM,
      S_ER_FIRE:  bus_wdata = CMD_ERASE;
      S_VF_CMD:   bus_wdata = CMD_VERIFY;
      S_VF_READ:  bus_op    = OP_READ;
      S_EXIT_OK,
      S_EXIT_ERR: bus_wdata = CMD_READ;
      default:    bus_req   = 1'b0;
    endcase
  end

  assign tmr_load = (st_q == S_ER_FIRE) && bus_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      pulse_q <= '0;
      max_q   <= PULSE_W'(1);
      ecyc_q  <= ERASE_CNT_W'(1);
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          addr_q  <= '0;
          pulse_q <= '0;
          max_q   <= (cfg_max_pulses == '0) ? PULSE_W'(1) : cfg_max_pulses;
          ecyc_q  <= cfg_erase_cycles;
          st_q    <= S_PP_CMD;
        end
        S_PP_CMD:  if (bus_ack) st_q <= S_PP_DATA;
        S_PP_DATA: if (bus_ack) st_q <= S_PP_READ;
        S_PP_READ: if (bus_ack) begin
          if (bus_rdata != PROG_VALUE) begin
            st_q <= S_EXIT_ERR;
          end else if (addr_q == LAST_ADDR) begin
            addr_q <= '0;
            st_q   <= S_ER_ARM;
          end else begin
            addr_q <= addr_q + 1'b1;
            st_q   <= S_PP_CMD;
          end
        end
        S_ER_ARM:  if (bus_ack) st_q <= S_ER_FIRE;
        S_ER_FIRE: if (bus_ack) begin
          pulse_q <= pulse_q + 1'b1;
          st_q    <= S_ER_WAIT;
        end
        S_ER_WAIT: if (tmr_expire) st_q <= S_VF_CMD;
        S_VF_CMD:  if (bus_ack) st_q <= S_VF_READ;
        S_VF_READ: if (bus_ack) begin
          if (bus_rdata == ERASED_BYTE) begin
            if (addr_q == LAST_ADDR) begin
              st_q <= S_EXIT_OK;
            end else begin
              addr_q <= addr_q + 1'b1;
              st_q   <= S_VF_CMD;
            end
          end else if (pulse_q >= max_q) begin
            st_q <= S_EXIT_ERR;
          end else begin
            st_q <= S_ER_ARM;
          end
        end
        S_EXIT_OK: if (bus_ack) begin
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        S_EXIT_ERR: if (bus_ack) begin
          err_q <= 1'b1;
          st_q  <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy  = (st_q != S_IDLE);
  assign done  = done_q;
  assign error = err_q;

  flash_bus_engine #(
    .ADDR_W    (ADDR_W),
    .WE_LOW_CYC(WE_LOW_CYC),
    .RD_CYC    (RD_CYC)
  ) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (bus_req),
    .req_op   (bus_op),
    .req_addr (addr_q),
    .req_data (bus_wdata),
    .ack      (bus_ack),
    .rdata    (bus_rdata),
    .fl_ce_n  (fl_ce_n),
    .fl_we_n  (fl_we_n),
    .fl_oe_n  (fl_oe_n),
    .fl_addr  (fl_addr),
    .fl_dq_out(fl_dq_out),
    .fl_dq_oe (fl_dq_oe),
    .fl_dq_in (fl_dq_in)
  );

  erase_interval_timer #(
    .CNT_W(ERASE_CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(ecyc_q),
    .expire  (tmr_expire)
  );

  // R4: the bus stays deselected through the erase interval
  a_r4_quiet_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ER_WAIT) |-> fl_ce_n && fl_we_n);
  // R8: pulse count never passes the captured cap
  a_r8_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pulse_q <= max_q);
  // R10: a start while busy does not recapture the configuration
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(max_q) && $stable(ecyc_q));
  // R10: terminal flags are exclusive and only present when idle
  a_r10_terminal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !busy && !(done && error));
  // R7: completion leaves the device bus idle
  a_r7_done_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> fl_ce_n && fl_we_n && fl_oe_n);

endmodule

// File: tb/tb_bulk_erase_sequencer.sv
module tb_bulk_erase_sequencer;

  localparam int AW  = 4;
  localparam int NB  = 1 << AW;
  localparam int ECW = 16;
  localparam int PW  = 8;
  localparam int WL  = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [ECW-1:0] cfg_erase_cycles = '0;
  logic [PW-1:0]  cfg_max_pulses = '0;
  logic           busy, done, error;
  logic           fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0]  fl_addr;
  logic [7:0]     fl_dq_out, fl_dq_in;

  always #2 clk = ~clk;

  bulk_erase_sequencer #(
    .ADDR_W(AW), .ERASE_CNT_W(ECW), .PULSE_W(PW), .WE_LOW_CYC(WL), .RD_CYC(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_erase_cycles(cfg_erase_cycles), .cfg_max_pulses(cfg_max_pulses),
    .busy(busy), .done(done), .error(error),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0]    arr [NB];
  int            need [NB];
  int            stuck_addr;
  int            pulses;
  bit            pp_armed, er_armed, vmode, measuring;
  logic [AW-1:0] vaddr;
  int            quiet_cnt;
  int            exp_quiet;
  bit            prev_we = 1'b1;

  assign fl_dq_in = (!fl_ce_n && !fl_oe_n)
                  ? (vmode ? ((pulses >= need[vaddr]) ? 8'hFF : 8'h7F) : arr[fl_addr])
                  : 8'h00;

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [AW-1:0] a;
    logic [7:0]    d;
    string         tag;
  } wr_t;
  wr_t expq[$];

  task automatic push(int a, logic [7:0] d, string tag);
    wr_t w;
    w.a = AW'(a);
    w.d = d;
    w.tag = tag;
    expq.push_back(w);
  endtask

  task automatic model_write(logic [AW-1:0] a, logic [7:0] d);
    int unprog;
    if (pp_armed) begin
      arr[a] = (int'(a) == stuck_addr) ? (d | 8'h04) : d;
      pp_armed = 1'b0;
    end else begin
      case (d)
        8'h40: begin pp_armed = 1'b1; er_armed = 1'b0; end
        8'h20: begin
          if (er_armed) begin
            er_armed = 1'b0;
            pulses++;
            if (pulses == 1) begin
              unprog = 0;
              for (int i = 0; i < NB; i++) if (arr[i] != 8'h00) unprog++;
              check(unprog == 0, "R2", "bytes not zero at first erase", unprog, 0);
            end
            measuring = 1'b1;
            quiet_cnt = 0;
          end else begin
            er_armed = 1'b1;
          end
        end
        8'hA0: begin
          er_armed = 1'b0;
          vmode = 1'b1;
          vaddr = a;
          if (measuring) begin
            measuring = 1'b0;
            check(quiet_cnt == exp_quiet, "R4", "deselected cycles in erase interval",
                  quiet_cnt, exp_quiet);
          end
        end
        default: begin vmode = 1'b0; er_armed = 1'b0; end
      endcase
    end
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (measuring && fl_ce_n) quiet_cnt++;
      if (!prev_we && fl_we_n) begin
        if (expq.size() == 0) begin
          check(1'b0, "R3", "unexpected bus write (data)", int'(fl_dq_out), 0);
        end else begin
          wr_t e;
          e = expq.pop_front();
          check(fl_addr == e.a && fl_dq_out == e.d, e.tag, "bus write addr/data",
                {fl_addr, fl_dq_out}, {e.a, e.d});
        end
        model_write(fl_addr, fl_dq_out);
      end
    end
    prev_we = fl_we_n;
  end

  // ---------------- driver ----------------
  task automatic reset_model();
    for (int i = 0; i < NB; i++) begin
      arr[i]  = 8'(i * 17 + 3);
      need[i] = 1;
    end
    stuck_addr = -1;
    pulses = 0;
    pp_armed = 1'b0;
    er_armed = 1'b0;
    vmode = 1'b0;
    measuring = 1'b0;
    quiet_cnt = 0;
  endtask

  task automatic build_expected(int maxp, output bit exp_err);
    int p;
    bit stop;
    exp_err = 1'b0;
    stop = 1'b0;
    for (int a = 0; a < NB && !stop; a++) begin
      push(a, 8'h40, "R2");
      push(a, 8'h00, "R2");
      if (a == stuck_addr) begin
        push(a, 8'h00, "R2");
        exp_err = 1'b1;
        stop = 1'b1;
      end
    end
    if (!exp_err) begin
      push(0, 8'h20, "R3");
      push(0, 8'h20, "R3");
      p = 1;
      for (int a = 0; a < NB && !stop; a++) begin
        push(a, 8'hA0, "R5");
        while (need[a] > p && !stop) begin
          if (p >= maxp) begin
            push(a, 8'h00, "R8");
            exp_err = 1'b1;
            stop = 1'b1;
          end else begin
            push(a, 8'h20, "R6");
            push(a, 8'h20, "R6");
            p++;
            push(a, 8'hA0, "R6");
          end
        end
      end
      if (!exp_err) push(NB - 1, 8'h00, "R7");
    end
  endtask

  task automatic run(int ecyc, int maxp, bit stray_start, string name);
    bit exp_err;
    int cyc;
    expq.delete();
    build_expected(maxp, exp_err);
    exp_quiet = ecyc + 1;
    cfg_erase_cycles = ECW'(ecyc);
    cfg_max_pulses = PW'(maxp);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && !error, "R10", {name, ": busy after start"},
          {busy, done, error}, 3'b100);
    cyc = 0;
    while (!(done || error) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (stray_start && cyc == 60) start = 1'b1;
      if (stray_start && cyc == 61) start = 1'b0;
    end
    check(cyc < 20000, "R10", {name, ": watchdog"}, cyc, 0);
    check(error == exp_err && done == !exp_err, exp_err ? "R8" : "R7",
          {name, ": done/error"}, {done, error}, {!exp_err, exp_err});
    check(!busy, "R10", {name, ": busy low at end"}, busy, 0);
    check(expq.size() == 0, exp_err ? "R8" : "R7", {name, ": writes left unissued"},
          expq.size(), 0);
    repeat (3) @(negedge clk);
    check(fl_ce_n && fl_we_n && fl_oe_n, "R11", {name, ": bus idle after run"},
          {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
  endtask

  initial begin
    reset_model();
    repeat (3) @(negedge clk);
    check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1", "bus levels in reset",
          {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error, "R1", "status after reset",
          {busy, done, error}, 3'b000);

    // uniform array, one pulse suffices (R2 R3 R4 R5 R7)
    reset_model();
    run(5, 4, 1'b0, "uniform");

    // weak bytes: resume at failing address, stray start mid-run (R6 R10)
    reset_model();
    need[3] = 2;
    need[10] = 4;
    run(3, 8, 1'b1, "weak_resume");

    // byte needing exactly the cap passes (R8 boundary)
    reset_model();
    need[7] = 3;
    run(1, 3, 1'b0, "cap_boundary");

    // byte beyond the cap aborts (R8)
    reset_model();
    need[4] = 2;
    need[12] = 5;
    run(2, 3, 1'b0, "cap_exceeded");

    // unprogrammable byte stops before erase (R2)
    reset_model();
    stuck_addr = 6;
    run(4, 8, 1'b0, "stuck_program");

    // clean run after an error clears status (R10)
    reset_model();
    run(7, 2, 1'b0, "after_error");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule